// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is the single-byte rotate, shift, nibble-swap and bit-operation datapath of a small 8-bit processor core. It is purely combinational. The core's decoder presents an operand byte, the current carry flag, a 4-bit operation code, a bit index and a marker for the short accumulator-only rotate forms. Within the same cycle the block returns the new byte, a write-enable for the destination, and four flag values (zero, subtract, half-carry, carry), each with its own update mask.

Operand fetch, memory cycles and instruction decode are handled by the surrounding core. The block has no state, clock or handshake. The core samples its outputs in the same cycle it drives the inputs, so no back-pressure applies.

Operation codes on `op_i`: 0 rotate-left-through-carry, 1 rotate-left-circular, 2 rotate-right-through-carry, 3 rotate-right-circular, 4 shift-left-arithmetic, 5 shift-right-arithmetic, 6 shift-right-logical, 7 nibble swap, 8 bit test, 9 bit clear, 10 bit set. Codes 11 to 15 are unused. The flag vectors are ordered with bit 3 = Z, bit 2 = N, bit 1 = H and bit 0 = C.

Top module: `rsb_unit`

## Requirements
- R1: Code 0 returns the operand shifted left with `carry_i` in bit 0, and the old bit 7 goes to C. Code 1 returns the operand shifted left with old bit 7 in both bit 0 and C.
- R2: Code 2 returns the operand shifted right with `carry_i` in bit 7, and the old bit 0 goes to C. Code 3 returns the operand shifted right with old bit 0 in both bit 7 and C.
- R3: Code 4 shifts left with 0 entering bit 0. Code 5 shifts right and keeps bit 7 unchanged. Code 6 shifts right with 0 entering bit 7. In all three the bit shifted out goes to C.
- R4: For codes 0 to 7, all four update masks are 1 and N = H = 0. When `acc_form_i` is low, or for codes 4 to 7, Z is 1 exactly when the result is zero.
- R5: With `acc_form_i` high, codes 0 to 3 force Z, N and H to 0 while result and C are unchanged. For every other code, `acc_form_i` has no effect on any output.
- R6: Code 7 exchanges the high and low nibbles and sets C to 0.
- R7: Code 8 sets Z when operand bit `bit_idx_i` is 0, N = 0 and H = 1. It updates Z, N and H (mask 4'b1110), leaves C alone, holds `wr_en_o` low and returns the operand on `result_o`.
- R8: Code 9 clears and code 10 sets operand bit `bit_idx_i` (bit 0 is the least significant). The other bits pass through unchanged, and all four update masks are 0.
- R9: `wr_en_o` is high for codes 0 to 7, 9 and 10.
- R10: Codes 11 to 15 return the operand, hold `wr_en_o` low and clear all update masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| bit_idx_i | input | 3 | Bit index for codes 8 to 10 |
| acc_form_i | input | 1 | Marks a short accumulator-only rotate |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result write-enable |
| flag_val_o | output | 4 | New Z, N, H, C values |
| flag_upd_o | output | 4 | Update mask for Z, N, H, C |

## Verification
The bound checker evaluates several properties whenever the inputs change. It checks that a bit test never writes and updates only Z, N and H with fixed N and H. It checks that clear and set leave the flags alone and change at most one bit. It checks that the accumulator forms zero Z, N and H, that circular rotates and the swap preserve the number of ones, and that unused codes do nothing. The exact bit placement of every rotate and shift, the carry that comes out, and Z computed from the result can only be shown by the bench. The bench applies every operand with both carry values, all eight bit indices, both accumulator markers and all sixteen codes against its own model.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [3:0] {
    OP_RLT  = 4'd0,
    OP_RLCI = 4'd1,
    OP_RRT  = 4'd2,
    OP_RRCI = 4'd3,
    OP_SHLA = 4'd4,
    OP_SHRA = 4'd5,
    OP_SHRL = 4'd6,
    OP_NSWP = 4'd7,
    OP_BTST = 4'd8,
    OP_BCLR = 4'd9,
    OP_BSET = 4'd10
  } rsb_op_e;

  localparam int FLG_Z = 3;
  localparam int FLG_N = 2;
  localparam int FLG_H = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/rsb_rotshift.sv
module rsb_rotshift #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic         cin_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] q_o,
  output logic         cout_o
);
  import rsb_pkg::*;
  localparam int HALF = W / 2;

  always_comb begin
    q_o    = d_i;
    cout_o = 1'b0;
    case (op_i)
      OP_RLT:  begin q_o = {d_i[W-2:0], cin_i};      cout_o = d_i[W-1]; end
      OP_RLCI: begin q_o = {d_i[W-2:0], d_i[W-1]};   cout_o = d_i[W-1]; end
      OP_RRT:  begin q_o = {cin_i, d_i[W-1:1]};      cout_o = d_i[0];   end
      OP_RRCI: begin q_o = {d_i[0], d_i[W-1:1]};     cout_o = d_i[0];   end
      OP_SHLA: begin q_o = {d_i[W-2:0], 1'b0};       cout_o = d_i[W-1]; end
      OP_SHRA: begin q_o = {d_i[W-1], d_i[W-1:1]};   cout_o = d_i[0];   end
      OP_SHRL: begin q_o = {1'b0, d_i[W-1:1]};       cout_o = d_i[0];   end
      OP_NSWP: begin q_o = {d_i[HALF-1:0], d_i[W-1:HALF]}; cout_o = 1'b0; end
      default: begin q_o = d_i; cout_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     d_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     clr_o,
  output logic [W-1:0]     set_o,
  output logic             sel_bit_o
);
  logic [W-1:0] onehot;

  for (genvar g = 0; g < W; g++) begin : g_dec
    assign onehot[g] = (idx_i == IDX_W'(g));
  end

  assign clr_o     = d_i & ~onehot;
  assign set_o     = d_i | onehot;
  assign sel_bit_o = |(d_i & onehot);
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     opnd_i,
  input  logic             carry_i,
  input  logic [3:0]       op_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             acc_form_i,
  output logic [W-1:0]     result_o,
  output logic             wr_en_o,
  output logic [3:0]       flag_val_o,
  output logic [3:0]       flag_upd_o
);
  import rsb_pkg::*;

  logic [W-1:0] rs_q, clr_q, set_q;
  logic         rs_c, sel_bit;
  logic         is_rot, short_rot;

  rsb_rotshift #(.W(W)) u_rs (
    .d_i(opnd_i), .cin_i(carry_i), .op_i(op_i), .q_o(rs_q), .cout_o(rs_c)
  );

  rsb_bitop #(.W(W), .IDX_W(IDX_W)) u_bo (
    .d_i(opnd_i), .idx_i(bit_idx_i), .clr_o(clr_q), .set_o(set_q), .sel_bit_o(sel_bit)
  );

  assign is_rot    = (op_i <= 4'(OP_RRCI));
  assign short_rot = is_rot & acc_form_i;

  always_comb begin
    result_o   = opnd_i;
    wr_en_o    = 1'b0;
    flag_val_o = '0;
    flag_upd_o = '0;
    if (op_i <= 4'(OP_NSWP)) begin
      result_o          = rs_q;
      wr_en_o           = 1'b1;
      flag_upd_o        = 4'b1111;
      flag_val_o[FLG_Z] = short_rot ? 1'b0 : (rs_q == '0);
      flag_val_o[FLG_C] = rs_c;
    end else begin
      case (op_i)
        OP_BTST: begin
          flag_upd_o        = 4'b1110;
          flag_val_o[FLG_Z] = ~sel_bit;
          flag_val_o[FLG_H] = 1'b1;
          flag_val_o[FLG_C] = carry_i;
        end
        OP_BCLR: begin result_o = clr_q; wr_en_o = 1'b1; end
        OP_BSET: begin result_o = set_q; wr_en_o = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opnd_i,
  input logic [3:0]   op_i,
  input logic         acc_form_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [3:0]   flag_val_o,
  input logic [3:0]   flag_upd_o
);
  import rsb_pkg::*;

  always_comb begin
    // R7
    bit_nowrite_chk: assert (op_i != 4'(OP_BTST) ||
      (!wr_en_o && flag_upd_o == 4'b1110 && !flag_val_o[FLG_N] && flag_val_o[FLG_H] && result_o == opnd_i));
    // R8
    resset_flag_chk: assert (!(op_i == 4'(OP_BCLR) || op_i == 4'(OP_BSET)) ||
      (flag_upd_o == 4'b0000 && $countones(result_o ^ opnd_i) <= 1));
    // R5
    accz_chk: assert (!(acc_form_i && op_i <= 4'(OP_RRCI)) ||
      (flag_val_o[FLG_Z:FLG_H] == 3'b000));
    // R6
    swap_c_chk: assert (op_i != 4'(OP_NSWP) ||
      (!flag_val_o[FLG_C] && $countones(result_o) == $countones(opnd_i)));
    // R1
    circ_pop_chk: assert (!(op_i == 4'(OP_RLCI) || op_i == 4'(OP_RRCI)) ||
      ($countones(result_o) == $countones(opnd_i)));
    // R10
    unused_chk: assert (op_i <= 4'(OP_BSET) ||
      (!wr_en_o && flag_upd_o == 4'b0000 && result_o == opnd_i));
  end
endmodule

bind rsb_unit rsb_unit_chk #(.W(W)) u_chk (
  .opnd_i(opnd_i), .op_i(op_i), .acc_form_i(acc_form_i), .result_o(result_o),
  .wr_en_o(wr_en_o), .flag_val_o(flag_val_o), .flag_upd_o(flag_upd_o)
);

// File: tb/sim_rsb_unit.sv
module sim_rsb_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 190000;

  logic       clk = 1'b0;
  logic [7:0] opnd;
  logic       cin;
  logic [3:0] op;
  logic [2:0] idx;
  logic       acc;
  logic [7:0] res;
  logic       wen;
  logic [3:0] fval, fupd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsb_unit u0 (
    .opnd_i(opnd), .carry_i(cin), .op_i(op), .bit_idx_i(idx), .acc_form_i(acc),
    .result_o(res), .wr_en_o(wen), .flag_val_o(fval), .flag_upd_o(fupd)
  );

  function automatic string tag_of(int o, int a);
    if (o <= 1) return (a != 0) ? "R5/R1" : "R1/R4";
    if (o <= 3) return (a != 0) ? "R5/R2" : "R2/R4";
    if (o <= 6) return "R3/R4";
    if (o == 7) return "R6";
    if (o == 8) return "R7";
    if (o <= 10) return "R8/R9";
    return "R10";
  endfunction

  task automatic apply(input int v, input int c, input int o, input int b, input int a);
    int r, co, z, n, h, we, upd;
    string t;
    opnd = v[7:0]; cin = c[0]; op = o[3:0]; idx = b[2:0]; acc = a[0];
    r = v; co = 0; n = 0; h = 0; we = 0; upd = 0; z = 0;
    case (o)
      0: begin r = ((v * 2) + c) % 256;        co = v / 128; end
      1: begin r = ((v * 2) + v / 128) % 256;  co = v / 128; end
      2: begin r = v / 2 + c * 128;            co = v % 2;   end
      3: begin r = v / 2 + (v % 2) * 128;     co = v % 2;   end
      4: begin r = (v * 2) % 256;              co = v / 128; end
      5: begin r = v / 2 + (v / 128) * 128;   co = v % 2;   end
      6: begin r = v / 2;                      co = v % 2;   end
      7: begin r = (v % 16) * 16 + v / 16;    co = 0;       end
      default: ;
    endcase
    if (o <= 7) begin
      we = 1; upd = 15;
      z = (o <= 3 && a != 0) ? 0 : (r == 0 ? 1 : 0);
    end else if (o == 8) begin
      upd = 14; h = 1; co = c;
      z = ((v >> b) % 2 == 0) ? 1 : 0;
    end else if (o == 9) begin
      we = 1; r = ((v >> b) % 2 == 1) ? v - (1 << b) : v;
    end else if (o == 10) begin
      we = 1; r = ((v >> b) % 2 == 0) ? v + (1 << b) : v;
    end
    @(negedge clk);
    t = tag_of(o, a);
    checks++;
    if (int'(res) != r || int'(wen) != we || int'(fupd) != upd ||
        ((int'(fval) & upd) != ((z * 8 + n * 4 + h * 2 + co) & upd))) begin
      fails++;
      $display("FAIL %s op=%0d v=%02h c=%0d i=%0d a=%0d: got res=%02h we=%0d val=%h upd=%h, exp res=%02h we=%0d val=%h upd=%h",
               t, o, v, c, b, a, res, wen, fval, fupd, r, we,
               (z * 8 + n * 4 + h * 2 + co) & upd, upd);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > LIMIT && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles, exp at most %0d", cycles, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    opnd = '0; cin = 1'b0; op = '0; idx = '0; acc = 1'b0;
    // Idle inputs: rotate of zero yields zero, Z set (R4)
    apply(0, 0, 0, 0, 0);
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 8; b++) begin
          if (o < 8 && b != 0 && a == 0) continue;
          if (o >= 8 && a == 1 && b != 0) continue;
          for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v++)
              apply(v, c, o, b, a);
        end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule